// File: doc/BRIEF.md
# Cache Peripheral Sleep Controller

This block decides, cycle by cycle, whether the peripheral circuits of a large second-level cache should be put to sleep. These circuits are the decoders, drivers and sense logic around the arrays. The block does no power gating itself. It drives one sleep line, plus a stall line that tells the requester that an access has to wait while the peripherals come back up.

The block has two policies, picked by a mode input.

In access-triggered mode the peripherals sleep by default. Each access opens an awake window of a programmable number of cycles. An access made while the window is open restarts the window and costs no wake-up.

In idle-triggered mode the block sleeps only while a miss is outstanding and the core has been quiet for a fixed number of consecutive cycles. It wakes a fixed number of cycles before the miss data is due. The miss latency is a fixed parameter, so a down-counter started at the miss marks the early-wake point.

Top module: `cache_periph_sleep_ctl`

## Requirements
- R1: During and right after reset, `sleep` is 1, `wake_stall` is 0 and access-triggered mode is active.
- R2: In access-triggered mode, take an access in cycle t with `window_len` equal to J and no further access. Then `sleep` is 0 in cycles t..t+J and 1 again in cycle t+J+1. J = 0 opens no window.
- R3: In access-triggered mode, an access made while the window is open raises no stall and restarts the window. After an access in cycle u, `sleep` stays 0 through cycle u+J.
- R4: In either mode, an access in a cycle where the block would otherwise sleep drives `wake_stall` to 1 and `sleep` to 0 in that same cycle. `wake_stall` is 0 in every other cycle.
- R5: `window_len` is 11 bits wide and the window length follows it exactly for any value up to 2047. This covers 100, 200, 500, 750 and 1500.
- R6: In idle-triggered mode, `sleep` is 1 only while a miss is outstanding. A miss is outstanding from the cycle after `miss_issue` until the cycle after `miss_return`.
- R7: In idle-triggered mode, take `miss_issue` in cycle t and no core activity after it. Then `sleep` first rises in cycle t+IDLE_K+1.
- R8: A cycle c with `core_issue` or `core_exec` high resets the quiet-cycle count. `sleep` is 0 from c+1, and rises again at c+IDLE_K+1 if the core stays quiet.
- R9: In idle-triggered mode, `sleep` is 0 from cycle t+MEM_LAT-EARLY_M onward for a miss issued in cycle t. That is EARLY_M cycles before the data is due.
- R10: `mode_sel` (0 = access-triggered, 1 = idle-triggered) is sampled every cycle. It takes effect in the next cycle only if, in the current cycle, no awake window is open, no idle sleep is active and no access arrives in access-triggered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested policy: 0 access-triggered, 1 idle-triggered |
| access | input | 1 | Cache access strobe for this cycle |
| miss_issue | input | 1 | A miss was sent to memory this cycle |
| miss_return | input | 1 | The outstanding miss is serviced this cycle |
| core_issue | input | 1 | The core issued an instruction this cycle |
| core_exec | input | 1 | A functional unit executed an instruction this cycle |
| window_len | input | WIN_W (11) | Awake window length J in cycles |
| sleep | output | 1 | Sleep request to the peripheral circuits |
| wake_stall | output | 1 | Access must wait for wake-up this cycle |

## Verification
The window length is measured for values from 0 up to the full 11-bit range. A counter that was off by one, or truncated to too few bits, would end the window a cycle early or late, or would wrap on the long settings. Restarting the window mid-way separates a true restart from a window that ignores the second access or that stalls on it. The idle-mode runs place core activity before and during sleep and an access in the middle of sleep. They check the exact cycles where sleep rises and where it drops early, which catches an idle counter that fails to clear and an early-wake point that is off by a cycle. Mode requests are also made during an open window and during an idle sleep. The bench then watches the single cycle that shows whether the switch was held back or taken at once.

// File: rtl/cache_periph_sleep_ctl.sv
module cache_periph_sleep_ctl #(
  parameter int WIN_W   = 11,
  parameter int IDLE_K  = 10,
  parameter int MEM_LAT = 300,
  parameter int EARLY_M = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             access,
  input  logic             miss_issue,
  input  logic             miss_return,
  input  logic             core_issue,
  input  logic             core_exec,
  input  logic [WIN_W-1:0] window_len,
  output logic             sleep,
  output logic             wake_stall
);
  localparam int IW = $clog2(IDLE_K + 1);
  localparam int LW = $clog2(MEM_LAT + 1);

  logic             mode_q;
  logic [WIN_W-1:0] win_cnt;
  logic             miss_busy;
  logic [LW-1:0]    lat_cnt;
  logic [IW-1:0]    idle_cnt;

  wire win_open   = win_cnt != '0;
  wire core_quiet = !core_issue && !core_exec;
  wire idle_ready = miss_busy && (idle_cnt == IW'(IDLE_K)) && (lat_cnt > LW'(EARLY_M));
  wire acc_asleep = !mode_q && !win_open;
  wire idl_asleep = mode_q && idle_ready;
  wire asleep     = acc_asleep || idl_asleep;
  wire hold_mode  = win_open || idl_asleep || (access && !mode_q);

  assign wake_stall = access && asleep;
  assign sleep      = asleep && !access;

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= 1'b0;
    else if (!hold_mode) mode_q <= mode_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 win_cnt <= '0;
    else if (access && !mode_q) win_cnt <= window_len;
    else if (win_open)          win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_busy <= 1'b0;
      lat_cnt   <= '0;
    end else if (miss_issue) begin
      miss_busy <= 1'b1;
      lat_cnt   <= LW'(MEM_LAT - 1);
    end else begin
      if (miss_return)    miss_busy <= 1'b0;
      if (lat_cnt != '0)  lat_cnt   <= lat_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !miss_busy || !core_quiet) idle_cnt <= '0;
    else if (idle_cnt != IW'(IDLE_K))        idle_cnt <= idle_cnt + 1'b1;
  end

  // R2
  window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !mode_q && window_len != '0) |=> !sleep);

  // R3
  no_stall_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !mode_q && win_open) |-> !wake_stall);

  // R4
  stall_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stall |-> (access && !sleep));

  // R6
  idle_sleep_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && sleep) |-> miss_busy);

  // R7
  idle_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IW'(IDLE_K));

  // R9
  early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && sleep) |-> (lat_cnt > LW'(EARLY_M)));

  // R10
  mode_switch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(!hold_mode));
endmodule

// File: tb/tb_cache_periph_sleep_ctl.sv
module tb_cache_periph_sleep_ctl;
  localparam int WW = 11;
  localparam int K  = 4;
  localparam int L  = 40;
  localparam int M  = 5;

  logic clk = 1'b0;
  logic rst_n, mode_sel, access, miss_issue, miss_return, core_issue, core_exec;
  logic [WW-1:0] window_len;
  logic sleep, wake_stall;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cache_periph_sleep_ctl #(.WIN_W(WW), .IDLE_K(K), .MEM_LAT(L), .EARLY_M(M)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .access(access),
    .miss_issue(miss_issue), .miss_return(miss_return), .core_issue(core_issue),
    .core_exec(core_exec), .window_len(window_len), .sleep(sleep), .wake_stall(wake_stall));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic window_run(input int j, input string req);
    int cnt;
    window_len = WW'(j);
    access = 1'b1;
    smp();
    check(wake_stall == 1'b1 && sleep == 1'b0, "R4", "stall on sleeping access", {wake_stall, sleep}, 2);
    tick();
    access = 1'b0;
    cnt = 0;
    smp();
    while (sleep == 1'b0 && cnt < 3000) begin
      cnt++;
      tick();
      smp();
    end
    check(cnt == j, req, "awake window length", cnt, j);
    tick();
  endtask

  task automatic idle_run(input int act_c, input int acc_c, input string req);
    int bad, first_c, act_v, exp_v;
    bit s_k, s_k1, s_e0, s_e1;
    bad = 0;
    first_c = -1;
    act_v = 0;
    exp_v = 0;
    for (int c = 0; c <= L + 3; c++) begin
      bit es, est;
      miss_issue  = (c == 0);
      miss_return = (c == L);
      core_issue  = (c == act_c);
      access      = (c == acc_c);
      smp();
      es = (c >= K + 1) && (c <= L - M - 1);
      if (act_c >= 0 && c > act_c && c <= act_c + K) es = 1'b0;
      est = 1'b0;
      if (c == acc_c) begin
        est = es;
        es = 1'b0;
      end
      if (sleep !== es || wake_stall !== est) begin
        bad++;
        if (first_c < 0) begin
          first_c = c;
          act_v = {sleep, wake_stall};
          exp_v = {es, est};
        end
      end
      if (c == K)         s_k  = sleep;
      if (c == K + 1)     s_k1 = sleep;
      if (c == L - M - 1) s_e0 = sleep;
      if (c == L - M)     s_e1 = sleep;
      tick();
    end
    miss_issue = 0; miss_return = 0; core_issue = 0; access = 0;
    check(bad == 0, req, $sformatf("idle trace mismatch at cycle %0d ({sleep,stall})", first_c), act_v, exp_v);
    if (act_c < 0 && acc_c < 0) begin
      check(s_k == 1'b0 && s_k1 == 1'b1, "R7", "sleep at K and K+1 quiet cycles", {s_k, s_k1}, 1);
      check(s_e0 == 1'b1 && s_e1 == 1'b0, "R9", "sleep before and at early wake", {s_e0, s_e1}, 2);
    end
    repeat (3) tick();
  endtask

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    int jl[11] = '{0, 1, 2, 3, 7, 100, 200, 500, 750, 1500, 2047};
    rst_n = 0; mode_sel = 0; access = 0; miss_issue = 0; miss_return = 0;
    core_issue = 0; core_exec = 0; window_len = '0;
    repeat (3) @(posedge clk);
    smp();
    check(sleep == 1'b1 && wake_stall == 1'b0, "R1", "reset outputs", {sleep, wake_stall}, 2);
    tick();
    rst_n = 1;
    smp();
    check(sleep == 1'b1 && wake_stall == 1'b0, "R1", "after reset outputs", {sleep, wake_stall}, 2);
    tick();

    foreach (jl[i]) window_run(jl[i], (jl[i] <= 7) ? "R2" : "R5");

    // R3: restart window mid-way
    window_len = 11'd10;
    access = 1;
    tick();
    access = 0;
    repeat (4) tick();
    access = 1;
    smp();
    check(wake_stall == 1'b0 && sleep == 1'b0, "R3", "access inside window", {wake_stall, sleep}, 0);
    tick();
    access = 0;
    cnt = 0;
    smp();
    while (sleep == 1'b0 && cnt < 100) begin
      cnt++;
      tick();
      smp();
    end
    check(cnt == 10, "R3", "restarted window length", cnt, 10);
    tick();

    // R10: switch to idle mode held back while window open
    window_len = 11'd20;
    access = 1;
    tick();
    access = 0;
    mode_sel = 1;
    repeat (20) tick();
    smp();
    check(sleep == 1'b1, "R10", "sleep at window expiry before switch", sleep, 1);
    tick();
    smp();
    check(sleep == 1'b0, "R10", "idle mode active after switch", sleep, 0);
    tick();

    // R6: idle mode, no miss, no sleep
    cnt = 0;
    for (int c = 0; c < 30; c++) begin
      smp();
      if (sleep) cnt++;
      tick();
    end
    check(cnt == 0, "R6", "sleep cycles without a miss", cnt, 0);

    idle_run(-1, -1, "R6");
    idle_run(10, -1, "R8");
    idle_run(3, -1, "R8");
    idle_run(-1, 20, "R4");

    // R10: switch back held while idle sleep is active
    for (int c = 0; c <= L + 2; c++) begin
      miss_issue  = (c == 0);
      miss_return = (c == L);
      if (c == 10) mode_sel = 0;
      smp();
      if (c == L - M)     check(sleep == 1'b0, "R10", "idle early wake before switch", sleep, 0);
      if (c == L - M + 1) check(sleep == 1'b1, "R10", "access mode sleep after switch", sleep, 1);
      tick();
    end
    miss_issue = 0; miss_return = 0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule